// File: doc/BRIEF.md
# Toggle-Chain Frequency Divider

This block divides a single clock by a whole number `N` that is fixed when the design is elaborated. The output is one square wave that repeats every `N` input cycles. Its high and low phases are as close to equal as the integer allows: for even `N` they match, and for odd `N` the low phase is one cycle longer.

The divider is a chain of toggle stages, one for each bit in the binary form of `N`. The last stage drives the output. The stages below it count down the length of the current half period. When that count reaches zero, the last stage toggles. At the same edge the lower stages move to the length of the next half period. They do this in one of two ways: some stages just follow the borrow ripple, and others XOR their toggle input with the terminal event and with the state of the last stage. No magnitude comparator and no reload multiplexer are needed.

Every stage steps on the one input clock through a synchronous toggle enable. No clock is derived and no analog delay is used.

Top module: `toggle_chain_divider`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, every stage clears and `div_out` is 0 after that edge.
- R2: At the first rising edge at which `rst_n` is high after reset, `div_out` goes to 1.
- R3: Each high phase of `div_out` lasts exactly floor(N/2) input cycles.
- R4: Each low phase after the first rise lasts exactly ceil(N/2) input cycles.
- R5: From one rising edge of `div_out` to the next is exactly `N` input cycles, for any `N` of 2 or more, odd or even.
- R6: The high and low phases differ by at most one cycle: they are equal for even `N`, and low is longer by one for odd `N`.
- R7: With `N` = 2, `div_out` changes value at every rising clock edge after reset.
- R8: Asserting `rst_n` low in the middle of a run forces `div_out` to 0. After release, the R2 to R4 sequence restarts from its first edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Input clock to be divided |
| rst_n | input | 1 | Synchronous reset, active low |
| div_out | output | 1 | Divided square wave, period N cycles |

## Verification
`div_out` is a registered output. It changes only at the rising edge at which the half-period count sits at zero. The first rise therefore lands on the first edge after reset is released, and every later transition comes floor(N/2) or ceil(N/2) edges after the one before it. The bench counts rising edges since the last reset edge and derives the expected level from that count alone. It compares this level with each instance's output at the falling edge that follows every rising edge, so each registered result is read one half cycle after it was produced. Separate measurements time whole high and low phases on several divisors, both odd and even, and a reset in the middle of the run checks that the edge count restarts.

// File: rtl/tcd_pkg.sv
// Package: shared types for the toggle-chain divider.
// Assumes nothing beyond standard SystemVerilog.
package tcd_pkg;

    // Toggle behaviour of one half-period stage.
    typedef enum logic [1:0] {
        CELL_PLAIN  = 2'd0,  // toggles on the borrow ripple only
        CELL_TERM   = 2'd1,  // borrow XOR terminal event
        CELL_FB     = 2'd2,  // borrow XOR (terminal AND last stage)
        CELL_FB_INV = 2'd3   // borrow XOR (terminal AND NOT last stage)
    } cell_kind_e;

    // Pick the stage variant from its bit of the low-phase load
    // and its bit of the difference between the two loads.
    function automatic cell_kind_e pick_kind(input logic base_bit,
                                             input logic diff_bit);
        if (!diff_bit)
            return base_bit ? CELL_PLAIN : CELL_TERM;
        return base_bit ? CELL_FB_INV : CELL_FB;
    endfunction

endpackage

// File: rtl/tcd_stage.sv
// Module: tcd_stage
// One toggle flip-flop of the half-period count. Its toggle input is the
// borrow from the stages below it. Depending on KIND, that input is also
// XORed with the terminal event and with the final output stage, so that at
// terminal count the stage lands on its bit of the next half-period load.
// Assumes term is high only when every stage of the count holds 0.
module tcd_stage
    import tcd_pkg::*;
#(
    parameter cell_kind_e KIND = CELL_PLAIN
) (
    input  logic clk,
    input  logic rst_n,
    input  logic borrow_in,
    input  logic term,
    input  logic fb,
    output logic q,
    output logic borrow_out
);

    logic flip;

    // Select the toggle-input variant for this bit position.
    generate
        case (KIND)
            CELL_PLAIN:  begin : g_plain
                assign flip = borrow_in;
            end
            CELL_TERM:   begin : g_term
                assign flip = borrow_in ^ term;
            end
            CELL_FB:     begin : g_fb
                assign flip = borrow_in ^ (term & fb);
            end
            default:     begin : g_fb_inv
                assign flip = borrow_in ^ (term & ~fb);
            end
        endcase
    endgenerate

    // Toggle register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (flip)
            q <= ~q;
    end

    // Borrow ripples upward only while this stage holds 0.
    assign borrow_out = borrow_in & ~q;

endmodule

// File: rtl/tcd_chain.sv
// Module: tcd_chain
// The lower CW stages of the divider. Together they form a down-counting
// toggle chain that holds the remaining length of the current half period.
// term rises when the chain holds zero. On that edge the chain moves to
// LO_LOAD or HI_LOAD, chosen by the final stage through XOR feedback.
// Assumes fb is the final stage and that it flips exactly when term is high.
module tcd_chain
    import tcd_pkg::*;
#(
    parameter int          CW      = 3,
    parameter logic [CW-1:0] LO_LOAD = '0,
    parameter logic [CW-1:0] HI_LOAD = '0
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          fb,
    output logic [CW-1:0] cnt,
    output logic          term
);

    localparam logic [CW-1:0] DIFF = LO_LOAD ^ HI_LOAD;

    logic [CW:0] borrow;

    assign borrow[0] = 1'b1;
    assign term      = borrow[CW];

    // One stage per bit, variant picked from the two load patterns.
    generate
        for (genvar i = 0; i < CW; i++) begin : g_stage
            localparam cell_kind_e K = pick_kind(LO_LOAD[i], DIFF[i]);
            tcd_stage #(.KIND(K)) u_stage (
                .clk       (clk),
                .rst_n     (rst_n),
                .borrow_in (borrow[i]),
                .term      (term),
                .fb        (fb),
                .q         (cnt[i]),
                .borrow_out(borrow[i+1])
            );
        end
    endgenerate

    // Away from terminal, the chain counts down by exactly one per cycle.
    assert_count_down_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> (cnt == CW'($past(cnt) - 1)));

    // Entering a high phase loads the high-phase length.
    assert_high_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && !fb) |=> (cnt == HI_LOAD));

    // Entering a low phase loads the low-phase length.
    assert_low_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0 && fb) |=> (cnt == LO_LOAD));

endmodule

// File: rtl/tcd_out_stage.sv
// Module: tcd_out_stage
// The last toggle stage of the chain, mapped to the top bit of N. It flips
// whenever the lower chain reaches terminal count and drives the output.
// Assumes term comes from the lower chain's borrow ripple.
module tcd_out_stage (
    input  logic clk,
    input  logic rst_n,
    input  logic term,
    output logic q
);

    // Output toggle register with synchronous active-low clear.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q <= 1'b0;
        else if (term)
            q <= ~q;
    end

endmodule

// File: rtl/toggle_chain_divider.sv
// Module: toggle_chain_divider
// Divide-by-N square wave generator built from $clog2(N+1) toggle stages.
// Stages below the top one count down the half period. The top stage is the
// output. High phase is floor(N/2) cycles and low phase is ceil(N/2) cycles.
// Assumes N >= 2. The reset is synchronous and active low.
module toggle_chain_divider #(
    parameter int N = 11
) (
    input  logic clk,
    input  logic rst_n,
    output logic div_out
);

    localparam int STAGES = $clog2(N + 1);
    localparam int CW     = STAGES - 1;
    localparam int HI_LEN = N / 2;
    localparam int LO_LEN = N - HI_LEN;
    localparam logic [CW-1:0] HI_LOAD = CW'(HI_LEN - 1);
    localparam logic [CW-1:0] LO_LOAD = CW'(LO_LEN - 1);

    logic [CW-1:0] cnt;
    logic          term;
    logic          out_q;

    // Half-period count: the lower toggle stages.
    tcd_chain #(
        .CW     (CW),
        .LO_LOAD(LO_LOAD),
        .HI_LOAD(HI_LOAD)
    ) u_chain (
        .clk  (clk),
        .rst_n(rst_n),
        .fb   (out_q),
        .cnt  (cnt),
        .term (term)
    );

    // Final stage, fed back to the XOR stages of the chain.
    tcd_out_stage u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .term (term),
        .q    (out_q)
    );

    assign div_out = out_q;

    // A reset edge clears the output and the count.
    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (!div_out && cnt == '0));

    // The output flips at every terminal count.
    assert_flip_at_term_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == '0) |=> (div_out != $past(div_out)));

    // The output holds while the count is still running.
    assert_hold_mid_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> $stable(div_out));

endmodule

// File: tb/toggle_chain_divider_test.sv
// Bench: several divisors side by side, compared each cycle with an
// edge-count model, plus whole-phase measurements and a mid-run reset.
module toggle_chain_divider_test;

    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic o11, o2, o3, o8, o100;
    int   ecnt = 0;
    int   checks = 0;
    int   fails = 0;
    bit   run_chk = 1'b0;
    bit   second_run = 1'b0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    toggle_chain_divider #(.N(11))  uut    (.clk(clk), .rst_n(rst_n), .div_out(o11));
    toggle_chain_divider #(.N(2))   uut_2  (.clk(clk), .rst_n(rst_n), .div_out(o2));
    toggle_chain_divider #(.N(3))   uut_3  (.clk(clk), .rst_n(rst_n), .div_out(o3));
    toggle_chain_divider #(.N(8))   uut_8  (.clk(clk), .rst_n(rst_n), .div_out(o8));
    toggle_chain_divider #(.N(100)) uut_100(.clk(clk), .rst_n(rst_n), .div_out(o100));

    // Edges since the last reset edge: the model's only state.
    always @(posedge clk) begin
        if (!rst_n) ecnt <= 0;
        else        ecnt <= ecnt + 1;
    end

    function automatic logic pick(input int n);
        case (n)
            2:   return o2;
            3:   return o3;
            8:   return o8;
            100: return o100;
            default: return o11;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle model compare for one divisor.
    task automatic cycle_check(input int n);
        int    e;
        string tag;
        logic  a;
        a = pick(n);
        e = (ecnt == 0) ? 0 : ((((ecnt - 1) % n) < (n / 2)) ? 1 : 0);
        if (n == 2 && ecnt > 0)  tag = "R7";
        else if (ecnt == 0)      tag = "R1";
        else if (ecnt == 1)      tag = second_run ? "R8" : "R2";
        else if (e == 1)         tag = "R3";
        else                     tag = "R4";
        check(tag, (a === 1'b1) ? 1 : ((a === 1'b0) ? 0 : -1), e,
              $sformatf("N=%0d edge %0d", n, ecnt));
    endtask

    always @(negedge clk) begin
        if (run_chk && !done) begin
            cycle_check(11);
            cycle_check(2);
            cycle_check(3);
            cycle_check(8);
            cycle_check(100);
        end
    end

    // Time one full high phase and the following low phase of divisor n.
    task automatic measure(input int n);
        logic prev, cur;
        int   hi, lo;
        @(negedge clk);
        prev = pick(n);
        forever begin
            @(negedge clk);
            cur = pick(n);
            if (!prev && cur) break;
            prev = cur;
        end
        hi = 1;
        forever begin
            @(negedge clk);
            if (!pick(n)) break;
            hi++;
        end
        lo = 1;
        forever begin
            @(negedge clk);
            if (pick(n)) break;
            lo++;
        end
        check("R5", hi + lo, n, $sformatf("period N=%0d", n));
        check("R6", lo - hi, n % 2, $sformatf("low minus high N=%0d", n));
        check("R3", hi, n / 2, $sformatf("high length N=%0d", n));
        check("R4", lo, n - n / 2, $sformatf("low length N=%0d", n));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        run_chk = 1'b1;
        rst_n = 1'b1;
        measure(11);
        measure(3);
        measure(2);
        measure(8);
        measure(100);
        measure(11);
        repeat (17) @(negedge clk);
        rst_n = 1'b0;               // R8: reset in the middle of a run
        repeat (2) @(negedge clk);
        second_run = 1'b1;
        rst_n = 1'b1;
        repeat (150) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule